// File: doc/BRIEF.md
# DMA Request Activation Sequencer

This block decides, for one DMA channel, when a transfer unit (one byte or one word) may begin and when the channel must give the bus back. A unit can be triggered in three ways. In edge mode, each falling edge on an active-low external request starts one unit. In level mode, units repeat while that request is held low. In auto mode, a write of the start strobe triggers the units, which then run until the block count is used up. Auto mode either steals single bus cycles or holds the bus for the whole block.

The sequencer raises a bus request and waits for the arbiter's grant. It then pulses a start strobe toward the transfer engine and waits for that engine's done pulse for the unit. A counter tracks the units left in the block. When the last unit finishes, the sequencer pulses an end-of-block flag and clears its own enable. The external request first passes through a two-flop synchronizer.

Top module: `dma_act_seq`

## Requirements
- R1: After reset, `bus_req`, `unit_start`, `block_end` and `active` are all low.
- R2: A `start` pulse with a nonzero `count_ld` sets `active` and loads the count. A `start` pulse with `count_ld` equal to zero has no effect. A `start` pulse while `active` is high has no effect, and the running block keeps its count.
- R3: With `mode` = 2'b00 (edge), each falling edge of `req_n` that arrives while the channel is idle produces exactly one unit. A falling edge that arrives while a unit is pending or running is dropped and is not queued.
- R4: With `mode` = 2'b01 (level), units repeat while `req_n` stays low. `bus_req` goes low for at least one cycle between units.
- R5: In level mode, if `req_n` returns high before the grant arrives, the request is withdrawn: `bus_req` falls, no unit starts, and the block stays `active`.
- R6: With `mode` = 2'b10 (auto) and `burst` = 0, units need no external input, and the bus is released after every unit.
- R7: With `mode` = 2'b10 and `burst` = 1, `bus_req` stays high from the first request until the block ends. In the external modes, `burst` has no effect.
- R8: `unit_start` is a one-cycle pulse. It is issued only while `bus_req` is high, and only in the cycle after `bus_gnt` was sampled high.
- R9: Each `unit_done` that arrives while a unit is running decrements the count. A `unit_done` at any other time is ignored.
- R10: The `unit_done` of the last unit produces a one-cycle `block_end`. In that same cycle, `active` and `bus_req` are both low. No further request is made until the next `start`, even if `req_n` is still low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | External transfer request, active low, asynchronous |
| mode | input | 2 | 00 edge, 01 level, 10 auto, 11 never triggers |
| burst | input | 1 | In auto mode: 1 burst, 0 cycle steal |
| start | input | 1 | Enable write strobe, loads `count_ld` |
| count_ld | input | CW | Units in the block |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| unit_done | input | 1 | Transfer engine finished the current unit |
| bus_req | output | 1 | Request for the bus |
| unit_start | output | 1 | Start strobe for one unit |
| block_end | output | 1 | Pulse when the count is exhausted |
| active | output | 1 | Channel enable |

## Verification
The completion of the final unit can land in the same cycle as a fresh trigger. In level mode, `req_n` is held low across the last `unit_done`, so the trigger is still present when the block ends. The check is that `block_end` appears with `bus_req` already low and that no further release or unit is counted afterwards. Edge mode gets the same treatment with extra falling edges sent after the block has ended. A second overlap is a request edge that falls on a unit in progress. The test stretches the done latency and checks that the unit total does not grow.

// File: rtl/dma_act_seq.sv
module dma_act_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_n,
  input  logic [1:0]    mode,
  input  logic          burst,
  input  logic          start,
  input  logic [CW-1:0] count_ld,
  input  logic          bus_gnt,
  input  logic          unit_done,
  output logic          bus_req,
  output logic          unit_start,
  output logic          block_end,
  output logic          active
);

  localparam logic [1:0] M_EDGE  = 2'b00;
  localparam logic [1:0] M_LEVEL = 2'b01;
  localparam logic [1:0] M_AUTO  = 2'b10;
  localparam logic [CW-1:0] ONE  = CW'(1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  st_t           st;
  logic [2:0]    rq;
  logic [CW-1:0] cnt;
  logic          req_low, req_fall, trig, last, keep_bus;

  assign req_low  = ~rq[1];
  assign req_fall = rq[2] & ~rq[1];
  assign last     = (cnt == ONE);
  assign keep_bus = (mode == M_AUTO) && burst;
  assign bus_req  = (st != S_IDLE);

  always_comb begin
    case (mode)
      M_EDGE:  trig = req_fall;
      M_LEVEL: trig = req_low;
      M_AUTO:  trig = 1'b1;
      default: trig = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq <= 3'b111;
    else        rq <= {rq[1:0], req_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      active     <= 1'b0;
      unit_start <= 1'b0;
      block_end  <= 1'b0;
    end else begin
      unit_start <= 1'b0;
      block_end  <= 1'b0;
      if (start && !active && count_ld != '0) begin
        active <= 1'b1;
        cnt    <= count_ld;
      end
      case (st)
        S_IDLE: if (active && trig) st <= S_WAIT;
        S_WAIT: begin
          if (mode == M_LEVEL && !req_low) st <= S_IDLE;
          else if (bus_gnt) begin
            st         <= S_RUN;
            unit_start <= 1'b1;
          end
        end
        S_RUN: if (unit_done) begin
          cnt <= cnt - ONE;
          if (last) begin
            active    <= 1'b0;
            block_end <= 1'b1;
            st        <= S_IDLE;
          end else if (keep_bus) begin
            if (bus_gnt) unit_start <= 1'b1;
            else         st <= S_WAIT;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_act_seq_chk.sv
module dma_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       burst,
  input logic       bus_gnt,
  input logic       bus_req,
  input logic       unit_start,
  input logic       block_end,
  input logic       active
);

  // R8
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> bus_req);

  // R8
  start_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_start |-> $past(bus_gnt));

  // R10
  end_drops_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> (!bus_req && !active));

  // R10
  end_not_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unit_start, block_end}));

  // R2
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !bus_req);

  // R7
  burst_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && mode == 2'b10 && burst) |-> !active);

endmodule

bind dma_act_seq dma_act_seq_chk u_chk (.*);

// File: tb/dma_act_seq_bench.sv
module dma_act_seq_bench;
  localparam int CW = 16;
  localparam time TCLK = 10ns;
  localparam int NV = 7;
  //                            auto cs, burst, burst1, level, edge, edge+extra, cs1
  localparam int V_MODE [NV] = '{2, 2, 2, 1, 0, 0, 2};
  localparam int V_BURST[NV] = '{0, 1, 1, 1, 1, 0, 0};
  localparam int V_CNT  [NV] = '{3, 4, 1, 3, 2, 2, 1};
  localparam int V_EDGES[NV] = '{0, 0, 0, 0, 2, 4, 0};
  localparam int V_UNITS[NV] = '{3, 4, 1, 3, 2, 2, 1};
  localparam int V_RELS [NV] = '{3, 1, 1, 3, 2, 2, 1};

  logic clk = 0, rst_n = 0, req_n = 1, burst = 0, start = 0, bus_gnt = 0, unit_done = 0;
  logic [1:0] mode = 2'b10;
  logic [CW-1:0] count_ld = '0;
  logic bus_req, unit_start, block_end, active;

  int checks = 0, fails = 0;
  int units = 0, rels = 0, ends = 0;
  int done_dly = 1, dcnt = 0;
  logic gnt_en = 1, force_done = 0, prev_req = 0;
  bit finished = 0;

  dma_act_seq #(.CW(CW)) u_dma_act_seq (
    .clk, .rst_n, .req_n, .mode, .burst, .start, .count_ld,
    .bus_gnt, .unit_done, .bus_req, .unit_start, .block_end, .active
  );

  always #(TCLK/2) clk = ~clk;

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  initial forever begin
    @(negedge clk);
    if (unit_start) begin units++; dcnt = done_dly; end
    if (block_end) begin
      ends++;
      // R10
      chk(!bus_req && !active, "R10 end drops bus", int'({bus_req, active}), 0);
    end
    if (prev_req && !bus_req) rels++;
    prev_req = bus_req;
    unit_done = force_done;
    if (dcnt > 0) begin dcnt--; if (dcnt == 0) unit_done = 1; end
    bus_gnt = bus_req & gnt_en;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask
  task automatic kick(int c);
    count_ld = CW'(c); start = 1; cyc(1); start = 0;
  endtask
  task automatic clr; units = 0; rels = 0; ends = 0; endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1
    chk(!bus_req && !unit_start && !block_end && !active, "R1 reset",
        int'({bus_req, unit_start, block_end, active}), 0);
    rst_n = 1; cyc(2);
    chk(!bus_req && !active, "R1 after release", int'({bus_req, active}), 0);

    for (int v = 0; v < NV; v++) begin
      clr(); mode = 2'(V_MODE[v]); burst = V_BURST[v][0];
      if (V_MODE[v] == 1) begin req_n = 0; cyc(4); end
      kick(V_CNT[v]);
      for (int e = 0; e < V_EDGES[v]; e++) begin
        req_n = 0; cyc(3); req_n = 1; cyc(30);
      end
      for (int t = 0; t < 300 && active; t++) cyc(1);
      cyc(10);
      req_n = 1; cyc(5);
      // R3 R4 R6 R7 R9
      chk(units == V_UNITS[v], $sformatf("R9 units vec %0d", v), units, V_UNITS[v]);
      // R4 R6 R7
      chk(rels == V_RELS[v], $sformatf("R7 releases vec %0d", v), rels, V_RELS[v]);
      // R10
      chk(ends == 1 && !bus_req, $sformatf("R10 single end vec %0d", v), ends, 1);
    end

    // R2 zero count ignored
    clr(); mode = 2'b10; burst = 0; kick(0); cyc(5);
    chk(!active && !bus_req && units == 0, "R2 zero count", int'(active), 0);

    // R8 grant gating, R9 stray done, R2 restart while active
    clr(); gnt_en = 0; kick(2); cyc(20);
    chk(bus_req && units == 0, "R8 no unit without grant", units, 0);
    force_done = 1; cyc(1); force_done = 0;
    kick(9); cyc(2);
    gnt_en = 1;
    for (int t = 0; t < 100 && active; t++) cyc(1);
    cyc(5);
    chk(units == 2 && ends == 1, "R9 stray done ignored / R2 restart ignored", units, 2);

    // R5 level withdrawal
    clr(); gnt_en = 0; mode = 2'b01; req_n = 0; cyc(3); kick(3); cyc(8);
    chk(bus_req == 1, "R5 request raised", int'(bus_req), 1);
    req_n = 1; cyc(6);
    chk(!bus_req && units == 0 && active, "R5 withdrawn", int'({bus_req, active}), 1);
    gnt_en = 1; req_n = 0;
    for (int t = 0; t < 100 && active; t++) cyc(1);
    req_n = 1; cyc(5);
    chk(units == 3, "R4 level completes", units, 3);

    // R3 edge during a running unit dropped
    clr(); mode = 2'b00; done_dly = 15; kick(2);
    req_n = 0; cyc(2); req_n = 1;
    for (int t = 0; t < 50 && units == 0; t++) cyc(1);
    req_n = 0; cyc(2); req_n = 1; cyc(40);
    chk(units == 1 && active, "R3 overlapping edge dropped", units, 1);
    req_n = 0; cyc(2); req_n = 1; cyc(40);
    chk(units == 2 && ends == 1 && !active, "R3 edge finishes block", units, 2);
    done_dly = 1;

    finish_run();
  end
endmodule